// File: doc/BRIEF.md
# Two-Bus Instruction Fetch Sequencer

This block is the front end of a small processor that carries out the instruction-fetch micro-operations.

It holds six pieces of state:
- a program counter (PC);
- a memory address register (MAR);
- a memory buffer register (MBR);
- an instruction register (IR);
- an ALU result latch (Z);
- an incrementing ALU.

Two internal buses connect them. The C-bus is the main transfer path. The B-bus feeds the ALU.

A sequencer steps through a fixed pattern of active-low strobes. The strobes gate register outputs, register loads, the external address driver, the memory data latch, the memory read and the ALU function. The memory side is an address bus, a data bus and an active-low read strobe. Memory returns data in the same cycle that the read strobe is low, with no wait states.

A pulse on `start` begins one fetch from idle. The `fast_mode` value sampled with that start selects between two fetches:
- the baseline four-cycle fetch;
- an overlapped three-cycle fetch, which increments the PC over the B-bus while the PC is also copied to the MAR, and writes the PC back during the memory read.

Each fetch ends with `done` high for its final cycle. After that the block returns to idle with every strobe high. At that point the IR holds the word read at the old PC, and the PC holds the old PC plus one.

Top module: `fetch_seq`

## Requirements
- R1: After reset, and in every idle cycle, all ten strobes are 1 (inactive). In those cycles `done` is 0, `pc_o` equals PC_RST after reset, and `ir_o` is 0 after reset.
- R2: In four-cycle mode (`fast_mode`=0 at start), the cycles after the start edge assert the following strobes low, with all other strobes 1:
  - cycle 1: `pc_oe_n`, `mar_ld_n`;
  - cycle 2: `addr_oe_n`, `mbr_ld_n`, `mem_rd_n`;
  - cycle 3: `pc_oe_n`, `mbr_oe_n`, `ir_ld_n`, `alu_inc_n`;
  - cycle 4: `z_oe_n`, `pc_ld_n`.
- R3: In three-cycle mode (`fast_mode`=1 at start), the cycles after the start edge assert the following strobes low, with all other strobes 1:
  - step 1: `pc_oe_n`, `mar_ld_n`, `alu_inc_n`;
  - step 2: `pc_ld_n`, `addr_oe_n`, `mbr_ld_n`, `z_oe_n`, `mem_rd_n`;
  - step 3: `mbr_oe_n`, `ir_ld_n`.
- R4: `pc_oe_n` goes low in exactly two cycles of a four-cycle fetch (cycles 1 and 3). In a three-cycle fetch it goes low only in step 1, which is also the only cycle in which the B-bus is used.
- R5: In the cycle where `addr_oe_n` is low, `mem_addr_o` equals the PC value from before the fetch. In every other cycle `mem_addr_o` is 0.
- R6: `done` is 1 for exactly one cycle: the final cycle of each fetch (cycle 4, or step 3). In the next cycle the block is idle.
- R7: After each fetch, `pc_o` equals the previous PC plus one, modulo 2^AW, so the all-ones PC wraps to 0.
- R8: After each fetch, `ir_o` equals the memory word that was returned at the previous PC.
- R9: `start` is ignored while a fetch is in progress, including the `done` cycle. A `start` held high therefore launches the next fetch one idle cycle after `done`.
- R10: The mode is captured at the start edge. A change on `fast_mode` during a fetch does not alter that fetch's pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch when idle |
| fast_mode | input | 1 | 1 selects the three-cycle fetch, sampled at start |
| mem_data_i | input | DW | Word returned by memory |
| mem_addr_o | output | AW | External address, 0 when the driver is off |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| pc_oe_n | output | 1 | PC output enable |
| pc_ld_n | output | 1 | PC load from C-bus |
| mar_ld_n | output | 1 | MAR load from C-bus |
| addr_oe_n | output | 1 | External address driver enable |
| mbr_ld_n | output | 1 | MBR latch of memory data |
| mbr_oe_n | output | 1 | MBR onto C-bus |
| ir_ld_n | output | 1 | IR load from C-bus |
| z_oe_n | output | 1 | Z onto C-bus |
| alu_inc_n | output | 1 | ALU increment of B-bus into Z |
| done | output | 1 | Final cycle of a fetch |
| pc_o | output | AW | Current PC |
| ir_o | output | DW | Current IR |

## Verification
The bench targets the following corner cases:

- **Strobes that differ between the two modes.** The pattern is compared against both tables on every cycle. A sequencer that dropped the increment from step 1, or left `pc_oe_n` high in cycle 3, would show a mismatched strobe word.
- **`start` held high through `done`.** A design that accepted `start` in the `done` cycle would begin the next fetch one cycle early, so every later strobe word would be offset by one cycle.
- **Toggling `fast_mode` inside a fetch.** A design that did not latch the mode would switch tables part-way through the fetch.
- **PC wrap.** Several hundred fetches carry the PC past the all-ones value. A design that got the increment or the Z write-back wrong would leave a PC that is not old plus one, and an IR word fetched from the wrong address.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] PC_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fast_mode,
  input  logic [DW-1:0] mem_data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_n,
  output logic          pc_oe_n,
  output logic          pc_ld_n,
  output logic          mar_ld_n,
  output logic          addr_oe_n,
  output logic          mbr_ld_n,
  output logic          mbr_oe_n,
  output logic          ir_ld_n,
  output logic          z_oe_n,
  output logic          alu_inc_n,
  output logic          done,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o
);

  localparam int SW = 3;
  localparam logic [SW-1:0] IDLE = '0;
  localparam logic [SW-1:0] LAST_SLOW = SW'(4);
  localparam logic [SW-1:0] LAST_FAST = SW'(3);

  logic [SW-1:0] step;
  logic          fast_r;
  logic [AW-1:0] pc_r, mar_r, z_r, cbus_a, bbus;
  logic [DW-1:0] mbr_r, ir_r, cbus;

  assign done = (step == (fast_r ? LAST_FAST : LAST_SLOW));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      step   <= IDLE;
      fast_r <= 1'b0;
    end else if (step == IDLE) begin
      if (start) begin
        step   <= SW'(1);
        fast_r <= fast_mode;
      end
    end else if (done) begin
      step <= IDLE;
    end else begin
      step <= step + SW'(1);
    end

  // strobe word: pc_oe pc_ld mar_ld addr_oe mbr_ld mbr_oe ir_ld z_oe alu_inc mem_rd
  logic [9:0] sw;
  always_comb begin
    sw = '1;
    unique case ({fast_r, step})
      {1'b0, SW'(1)}: sw = 10'b0101111111;
      {1'b0, SW'(2)}: sw = 10'b1110011110;
      {1'b0, SW'(3)}: sw = 10'b0111100101;
      {1'b0, SW'(4)}: sw = 10'b1011111011;
      {1'b1, SW'(1)}: sw = 10'b0101111101;
      {1'b1, SW'(2)}: sw = 10'b1010011010;
      {1'b1, SW'(3)}: sw = 10'b1111100111;
      default:        sw = '1;
    endcase
  end

  assign {pc_oe_n, pc_ld_n, mar_ld_n, addr_oe_n, mbr_ld_n,
          mbr_oe_n, ir_ld_n, z_oe_n, alu_inc_n, mem_rd_n} = sw;

  assign cbus_a = !z_oe_n ? z_r : pc_r;
  assign cbus   = !mbr_oe_n ? mbr_r : DW'(cbus_a);
  assign bbus   = pc_r;
  assign mem_addr_o = addr_oe_n ? '0 : mar_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc_r  <= PC_RST;
      mar_r <= '0;
      z_r   <= '0;
      mbr_r <= '0;
      ir_r  <= '0;
    end else begin
      if (!pc_ld_n)   pc_r  <= cbus[AW-1:0];
      if (!mar_ld_n)  mar_r <= cbus[AW-1:0];
      if (!alu_inc_n) z_r   <= bbus + AW'(1);
      if (!mbr_ld_n)  mbr_r <= mem_data_i;
      if (!ir_ld_n)   ir_r  <= cbus;
    end

  assign pc_o = pc_r;
  assign ir_o = ir_r;

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_addr_is_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> mem_addr_o == $past(pc_r));
  a_r7_pc_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_r != $past(pc_r)) |-> pc_r == $past(pc_r) + AW'(1));
  a_r8_ir_from_mbr: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_ld_n |=> ir_r == $past(mbr_r));
  a_r4_cbus_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!mbr_oe_n, !z_oe_n, !pc_oe_n && alu_inc_n}));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (mem_rd_n && pc_ld_n && ir_ld_n && alu_inc_n));

endmodule

// File: tb/sim_fetch_seq.sv
module sim_fetch_seq;
  localparam int AW = 8, DW = 16;

  logic clk = 0, rst_n = 0, start = 0, fast_mode = 0;
  logic [DW-1:0] mem_data;
  logic [AW-1:0] mem_addr, pc_o;
  logic [DW-1:0] ir_o;
  logic mem_rd_n, pc_oe_n, pc_ld_n, mar_ld_n, addr_oe_n, mbr_ld_n;
  logic mbr_oe_n, ir_ld_n, z_oe_n, alu_inc_n, done;

  always #10 clk = ~clk;

  fetch_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fast_mode(fast_mode),
    .mem_data_i(mem_data), .mem_addr_o(mem_addr), .mem_rd_n(mem_rd_n),
    .pc_oe_n(pc_oe_n), .pc_ld_n(pc_ld_n), .mar_ld_n(mar_ld_n),
    .addr_oe_n(addr_oe_n), .mbr_ld_n(mbr_ld_n), .mbr_oe_n(mbr_oe_n),
    .ir_ld_n(ir_ld_n), .z_oe_n(z_oe_n), .alu_inc_n(alu_inc_n),
    .done(done), .pc_o(pc_o), .ir_o(ir_o));

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {a * 8'd37 ^ 8'h5A, ~a};
  endfunction
  assign mem_data = mem_rd_n ? 16'hDEAD : memf(mem_addr);

  int compared = 0, mismatched = 0, cycles = 0;
  bit finished = 0;
  logic [11:0] q[$];
  logic [AW-1:0] mpc = '0;
  logic [DW-1:0] mir = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // reference model: {fast, done, strobes} per cycle of a fetch
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
    end
    if (rst_n) begin
      if (q.size() > 0) begin
        logic [11:0] e;
        e = q.pop_front();
        if (e[10]) begin mir = memf(mpc); mpc = mpc + 1'b1; end
      end else if (start) begin
        if (fast_mode) begin
          q.push_back({2'b10, 10'b0101111101});
          q.push_back({2'b10, 10'b1010011010});
          q.push_back({2'b11, 10'b1111100111});
        end else begin
          q.push_back({2'b00, 10'b0101111111});
          q.push_back({2'b00, 10'b1110011110});
          q.push_back({2'b00, 10'b0111100101});
          q.push_back({2'b01, 10'b1011111011});
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [11:0] e;
    logic [9:0] act;
    e = (q.size() > 0) ? q[0] : {2'b00, 10'h3FF};
    act = {pc_oe_n, pc_ld_n, mar_ld_n, addr_oe_n, mbr_ld_n,
           mbr_oe_n, ir_ld_n, z_oe_n, alu_inc_n, mem_rd_n};
    if (q.size() == 0) begin
      chk("R1 idle strobes", 32'(act), 32'(e[9:0]));
      chk("R7 pc", 32'(pc_o), 32'(mpc));
      chk("R8 ir", 32'(ir_o), 32'(mir));
    end else if (e[11]) chk("R3 fast strobes (R4 R9 R10)", 32'(act), 32'(e[9:0]));
    else chk("R2 slow strobes (R4 R9 R10)", 32'(act), 32'(e[9:0]));
    chk("R6 done", 32'(done), 32'(e[10]));
    chk("R5 address", 32'(mem_addr), e[6] ? 32'(0) : 32'(mpc));
  end

  task automatic fetch(input bit fm);
    @(negedge clk); start = 1; fast_mode = fm;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset pc", 32'(pc_o), 32'(0));
    chk("R1 reset ir", 32'(ir_o), 32'(0));
    fetch(0); fetch(1); fetch(0); fetch(1);
    // R9: start held through several fetches
    @(negedge clk); start = 1; fast_mode = 0;
    repeat (14) @(negedge clk);
    fast_mode = 1;
    repeat (10) @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    // R10: toggle mode inside a fetch
    @(negedge clk); start = 1; fast_mode = 0;
    @(negedge clk); start = 0; fast_mode = 1;
    @(negedge clk); fast_mode = 0;
    repeat (5) @(negedge clk);
    @(negedge clk); start = 1; fast_mode = 1;
    @(negedge clk); start = 0; fast_mode = 0;
    repeat (5) @(negedge clk);
    // R7 wrap: run past PC 255
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); start = 1; fast_mode = 1'($urandom);
      @(negedge clk); start = $urandom_range(0, 1) == 1;
      repeat ($urandom_range(4, 6)) @(negedge clk);
      start = 0;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    summary();
  end
endmodule